// File: doc/BRIEF.md
# Memory Backfill Chip-Select Decoder

This block selects a single 512 KB SRAM on an 8-bit expansion card from the top four bits of a 20-bit memory address. A first one-of-four decode always splits the 1 MB space into 256 KB quarters. The quarter at 40000–7FFFF selects the SRAM directly. The quarter at 80000–BFFFF enables a second one-of-four decode that splits it into 64 KB segments. Segments 80000 and 90000 select the SRAM. Segment A0000 selects it only when a jumper input allows it. Segment B0000 never selects it. All select terms are active low and are combined with an AND, so any one term going low pulls the chip enable low.

Address bit 18 goes to the SRAM unchanged. The 40000–7FFFF window therefore lands in the upper half of the SRAM, and 80000–AFFFF lands at SRAM 00000–2FFFF. A data transceiver enable tracks the chip enable, and its direction comes from the read strobe. Two active-low indicator outputs show host-owned memory accesses and accesses to the B0000 video segment. Every output is qualified by a memory strobe, and every output is captured in one output register stage so it can be sampled cleanly.

Top module: `bf_backfill_decoder`

## Requirements
- R1: While reset is asserted and on the first sample after it, sram_ce_n, xcvr_en_n, sys_led_n, vid_led_n and xcvr_dir are all 1, and sram_a18 is 0.
- R2: Every output reflects the inputs present at the previous rising clock edge. Before the next edge, an output still shows the earlier result.
- R3: With a strobe low, addr_hi values 4 to 7 (addresses 40000–7FFFF) drive sram_ce_n to 0.
- R4: With a strobe low, addr_hi values 8 and 9 drive sram_ce_n to 0.
- R5: With a strobe low, addr_hi value 10 (A0000) drives sram_ce_n to 0 when seg_a_en is 1, and leaves it at 1 when seg_a_en is 0.
- R6: addr_hi value 11 (B0000) never drives sram_ce_n to 0. With a strobe low, it drives vid_led_n to 0.
- R7: With a strobe low, addr_hi values 0 to 3 and 12 to 15 drive sys_led_n to 0. All other values leave it at 1.
- R8: When memr_n and memw_n are both 1, sram_ce_n, xcvr_en_n, sys_led_n and vid_led_n are all 1, whatever the address or jumper value.
- R9: xcvr_en_n equals sram_ce_n, and xcvr_dir equals memr_n, both taken from the same edge.
- R10: sram_ca18 equals addr_hi[2]. So addr_hi 8, 9 and 10 reach the SRAM with bit 18 equal to 0.
- R11: At most one of sram_ce_n, sys_led_n and vid_led_n is 0 at any time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock for the output register |
| rst_n | input | 1 | Active-low reset of the output register |
| addr_hi | input | 4 | Address bits 19..16 |
| memr_n | input | 1 | Active-low memory read strobe |
| memw_n | input | 1 | Active-low memory write strobe |
| seg_a_en | input | 1 | Jumper: 1 lets segment A0000 select the SRAM; 0 (open, pulled inactive) blocks it |
| sram_ce_n | output | 1 | Active-low SRAM chip enable |
| sram_a18 | output | 1 | Address bit 18 passed to the SRAM |
| xcvr_en_n | output | 1 | Active-low data transceiver enable |
| xcvr_dir | output | 1 | Transceiver direction, copied from memr_n |
| sys_led_n | output | 1 | Active-low indicator for accesses to host-owned memory |
| vid_led_n | output | 1 | Active-low indicator for accesses to segment B0000 |

## Verification
A wrong quarter or segment decode shows as a wrong level on sram_ce_n or on one of the indicators one clock after the address is applied. Sweeping all sixteen address values with the jumper open and closed exposes each such fault within one cycle. A broken strobe qualification shows as a select that appears while both strobes are high, again one cycle later. A mis-wired bit 18 path shows on sram_a18 for every address whose bit 18 is 1.

// File: rtl/bf_pkg.sv
package bf_pkg;
    localparam int ADDR_HI_W = 4;
    localparam int SEL_W     = 2;
    localparam int WAYS      = 1 << SEL_W;
    // quarter indices of the first decode stage
    localparam int Q_LOW   = 0;
    localparam int Q_DIRECT = 1;
    localparam int Q_SPLIT = 2;
    localparam int Q_HIGH  = 3;
    // segment indices of the second decode stage
    localparam int S_FIRST = 0;
    localparam int S_SECOND = 1;
    localparam int S_JUMPER = 2;
    localparam int S_VIDEO = 3;

    typedef struct packed {
        logic ce_n;
        logic a18;
        logic xen_n;
        logic dir;
        logic sys_n;
        logic vid_n;
    } bf_out_t;

    localparam bf_out_t BF_IDLE = '{ce_n: 1'b1, a18: 1'b0, xen_n: 1'b1,
                                    dir: 1'b1, sys_n: 1'b1, vid_n: 1'b1};
endpackage

// File: rtl/bf_dec_stage.sv
module bf_dec_stage #(
    parameter int SEL_W = 2,
    localparam int WAYS = 1 << SEL_W
) (
    input  logic             en_n,
    input  logic [SEL_W-1:0] sel,
    output logic [WAYS-1:0]  y_n
);
    for (genvar i = 0; i < WAYS; i++) begin : g_way
        assign y_n[i] = en_n | (sel != SEL_W'(i));
    end
endmodule

// File: rtl/bf_low_merge.sv
module bf_low_merge #(
    parameter int N = 4
) (
    input  logic [N-1:0] term_n,
    output logic         any_n
);
    // any low term pulls the result low
    assign any_n = &term_n;
endmodule

// File: rtl/bf_backfill_decoder.sv
module bf_backfill_decoder
    import bf_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [ADDR_HI_W-1:0] addr_hi,
    input  logic                 memr_n,
    input  logic                 memw_n,
    input  logic                 seg_a_en,
    output logic                 sram_ce_n,
    output logic                 sram_a18,
    output logic                 xcvr_en_n,
    output logic                 xcvr_dir,
    output logic                 sys_led_n,
    output logic                 vid_led_n
);
    localparam int MERGE_N = 4;

    logic [WAYS-1:0]    quarter_n;
    logic [WAYS-1:0]    segment_n;
    logic               seg_a_term_n;
    logic [MERGE_N-1:0] sel_terms_n;
    logic               hit_n;
    logic               strobe_n;
    bf_out_t            nxt;
    bf_out_t            cur;

    bf_dec_stage #(.SEL_W(SEL_W)) u_quarter (
        .en_n (1'b0),
        .sel  (addr_hi[ADDR_HI_W-1 -: SEL_W]),
        .y_n  (quarter_n)
    );

    bf_dec_stage #(.SEL_W(SEL_W)) u_segment (
        .en_n (quarter_n[Q_SPLIT]),
        .sel  (addr_hi[SEL_W-1:0]),
        .y_n  (segment_n)
    );

    // open jumper reads as inactive
    assign seg_a_term_n = segment_n[S_JUMPER] | ~seg_a_en;
    assign sel_terms_n  = {seg_a_term_n, segment_n[S_SECOND],
                           segment_n[S_FIRST], quarter_n[Q_DIRECT]};

    bf_low_merge #(.N(MERGE_N)) u_merge (
        .term_n (sel_terms_n),
        .any_n  (hit_n)
    );

    assign strobe_n = memr_n & memw_n;

    always_comb begin
        nxt.ce_n  = hit_n | strobe_n;
        nxt.a18   = addr_hi[SEL_W];
        nxt.xen_n = hit_n | strobe_n;
        nxt.dir   = memr_n;
        nxt.sys_n = (quarter_n[Q_LOW] & quarter_n[Q_HIGH]) | strobe_n;
        nxt.vid_n = segment_n[S_VIDEO] | strobe_n;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cur <= BF_IDLE;
        else        cur <= nxt;
    end

    assign sram_ce_n = cur.ce_n;
    assign sram_a18  = cur.a18;
    assign xcvr_en_n = cur.xen_n;
    assign xcvr_dir  = cur.dir;
    assign sys_led_n = cur.sys_n;
    assign vid_led_n = cur.vid_n;

    // R8
    no_strobe_select_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !sram_ce_n |-> $past(!memr_n || !memw_n));

    // R6
    video_never_sram_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !vid_led_n |-> ($past(addr_hi) == 4'hB && sram_ce_n));

    // R5
    jumper_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!sram_ce_n && $past(addr_hi) == 4'hA) |-> $past(seg_a_en));

    // R11
    single_owner_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({~sram_ce_n, ~sys_led_n, ~vid_led_n}));

    // R10
    a18_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> sram_a18 == $past(addr_hi[2]));
endmodule

// File: tb/sim_bf_backfill_decoder.sv
module sim_bf_backfill_decoder;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] addr_hi = 4'h0;
    logic       memr_n = 1'b1;
    logic       memw_n = 1'b1;
    logic       seg_a_en = 1'b0;
    logic       sram_ce_n, sram_a18, xcvr_en_n, xcvr_dir, sys_led_n, vid_led_n;
    int         checks = 0;
    int         errors = 0;

    // rows: 0 ce open jumper, 1 ce closed jumper, 2 sys, 3 vid (bit index = addr_hi)
    localparam logic [15:0] EXP [4] = '{
        16'b1111_1100_0000_1111,
        16'b1111_1000_0000_1111,
        16'b0000_1111_1111_0000,
        16'b1111_0111_1111_1111
    };

    always #2 clk = ~clk;

    bf_backfill_decoder u0 (
        .clk(clk), .rst_n(rst_n), .addr_hi(addr_hi), .memr_n(memr_n),
        .memw_n(memw_n), .seg_a_en(seg_a_en), .sram_ce_n(sram_ce_n),
        .sram_a18(sram_a18), .xcvr_en_n(xcvr_en_n), .xcvr_dir(xcvr_dir),
        .sys_led_n(sys_led_n), .vid_led_n(vid_led_n)
    );

    task automatic check(input string req, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0b expected=%0b addr=%h jmp=%0b", req, act, exp,
                     addr_hi, seg_a_en);
        end
    endtask

    // drive at negedge, sample after the following posedge
    task automatic apply(input logic [3:0] a, input logic r, input logic w, input logic j);
        @(negedge clk);
        addr_hi = a; memr_n = r; memw_n = w; seg_a_en = j;
        @(posedge clk);
        #1;
    endtask

    initial begin
        #100000;
        errors++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        // R1: reset state
        @(negedge clk); @(negedge clk);
        check("R1 ce", sram_ce_n, 1'b1);
        check("R1 xen", xcvr_en_n, 1'b1);
        check("R1 sys", sys_led_n, 1'b1);
        check("R1 vid", vid_led_n, 1'b1);
        check("R1 dir", xcvr_dir, 1'b1);
        check("R1 a18", sram_a18, 1'b0);
        rst_n = 1'b1;
        #1;
        check("R1 ce after release", sram_ce_n, 1'b1);

        // sweep: R3 R4 R5 R6 R7 R9 R10
        for (int j = 0; j < 2; j++) begin
            for (int a = 0; a < 16; a++) begin
                logic rd;
                rd = a[0];
                apply(4'(a), ~rd, rd, 1'(j));
                check("R3/R4/R5/R6 ce", sram_ce_n, EXP[j][a]);
                check("R9 xen", xcvr_en_n, EXP[j][a]);
                check("R9 dir", xcvr_dir, ~rd);
                check("R7 sys", sys_led_n, EXP[2][a]);
                check("R6 vid", vid_led_n, EXP[3][a]);
                check("R10 a18", sram_a18, a[2]);
            end
        end

        // R8: no strobe, nothing selected
        for (int j = 0; j < 2; j++) begin
            for (int a = 0; a < 16; a++) begin
                apply(4'(a), 1'b1, 1'b1, 1'(j));
                check("R8 ce", sram_ce_n, 1'b1);
                check("R8 xen", xcvr_en_n, 1'b1);
                check("R8 sys", sys_led_n, 1'b1);
                check("R8 vid", vid_led_n, 1'b1);
            end
        end

        // R5 corner: segment A with both strobes low
        apply(4'hA, 1'b0, 1'b0, 1'b0);
        check("R5 open", sram_ce_n, 1'b1);
        apply(4'hA, 1'b0, 1'b0, 1'b1);
        check("R5 closed", sram_ce_n, 1'b0);

        // R2: one cycle latency
        apply(4'h5, 1'b0, 1'b1, 1'b0);
        check("R2 settled", sram_ce_n, 1'b0);
        @(negedge clk);
        addr_hi = 4'hB;
        #1;
        check("R2 held before edge", sram_ce_n, 1'b0);
        @(posedge clk); #1;
        check("R2 after edge", sram_ce_n, 1'b1);
        check("R2 vid after edge", vid_led_n, 1'b0);

        // R1: reset in mid traffic
        apply(4'h4, 1'b0, 1'b1, 1'b0);
        rst_n = 1'b0;
        #1;
        check("R1 async ce", sram_ce_n, 1'b1);
        check("R1 async a18", sram_a18, 1'b0);
        rst_n = 1'b1;

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule